// File: doc/BRIEF.md
# Pipelined Inner Product Accumulator

This block computes the dot product of two signed integer vectors that arrive one element pair per clock. Each pair goes through a multiplier pipeline with several segments. The product then enters an adder pipeline whose last register feeds straight back to its own input. The adder ring therefore holds one independent partial sum per segment. Each new product is added to whichever partial sum is coming back around the loop at that moment.

The ring registers start at zero, so the first products of a vector add to nothing. When the element marked last has been accepted, the block stops taking input and waits for the multiplier to empty. It then adds every partial sum in the ring into one scalar. It presents that scalar with a one-cycle done pulse and clears the ring for the next vector.

An upstream source drives `in_valid`, `in_last` and the two operands. An element is taken on any rising edge where both `in_valid` and `in_ready` are high. Only one vector is in flight at a time.

Top module: `dot_product_accum`

## Requirements
- R1: An element pair is accepted on every rising edge where `in_valid` and `in_ready` are both high, so an unbroken stream is taken at one pair per clock.
- R2: `out_sum` equals the two's-complement signed sum of `in_a * in_b` over every pair accepted since the previous done pulse, up to and including the pair marked by `in_last`.
- R3: `out_valid` is high for exactly one cycle. That cycle begins `MUL_STAGES + 1` rising edges after the edge that accepted the last pair (5 edges with the defaults).
- R4: `in_ready` is low from the cycle after the last pair is accepted until the done cycle, and high again in the done cycle. Input presented while `in_ready` is low has no effect on any result.
- R5: Vectors of one, two or three pairs give the exact sum; the partial sums that received no product count as zero.
- R6: Cycles with `in_valid` low in the middle of a vector add nothing and do not change the result.
- R7: The accumulator is `2*OP_W + clog2(MAX_LEN)` bits wide. A vector of `MAX_LEN` pairs of the most negative operand value yields its exact sum without overflow.
- R8: After reset `in_ready` is high, `out_valid` is low and `out_sum` is zero.
- R9: `out_sum` keeps its value from one done pulse until the next.
- R10: A new vector may start in the done cycle of the previous one, and its sum starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element pair present on `in_a`/`in_b` |
| in_last | input | 1 | Marks the final pair of the vector |
| in_a | input | OP_W | First operand, signed |
| in_b | input | OP_W | Second operand, signed |
| in_ready | output | 1 | High when a pair can be accepted |
| out_valid | output | 1 | One-cycle done pulse with the result |
| out_sum | output | 2*OP_W+clog2(MAX_LEN) | Signed inner product, held until the next done |

## Verification
The hardest case to reach from the ports is a set of partial sums that are uneven or partly empty when the reduction starts. Vectors of one to five and nine pairs cover this, as do vectors with idle gaps that move products into different ring slots. Overflow is probed by a full-length vector of the largest-magnitude product. During every drain the stimulus keeps `in_valid` high with junk operands, to show that nothing enters. The next vector's first pair is offered in the exact done cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic {
    ST_ACCUM = 1'b0,
    ST_DRAIN = 1'b1
  } dpa_state_t;

endpackage

// File: rtl/dpa_mult_pipe.sv
module dpa_mult_pipe #(
  parameter int OP_W   = 16,
  parameter int STAGES = 4,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_i,
  input  logic signed [OP_W-1:0]   a_i,
  input  logic signed [OP_W-1:0]   b_i,
  output logic signed [PROD_W-1:0] prod_o,
  output logic                     busy_o
);

  function automatic logic signed [PROD_W-1:0] full_mul(
    input logic signed [OP_W-1:0] x,
    input logic signed [OP_W-1:0] y
  );
    logic signed [PROD_W-1:0] xw;
    logic signed [PROD_W-1:0] yw;
    xw = x;
    yw = y;
    return xw * yw;
  endfunction

  logic signed [PROD_W-1:0] prod_q [STAGES];
  logic [STAGES-1:0]        vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < STAGES; s++) prod_q[s] <= '0;
    end else begin
      vld_q[0]  <= take_i;
      prod_q[0] <= take_i ? full_mul(a_i, b_i) : '0;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s]  <= vld_q[s-1];
        prod_q[s] <= prod_q[s-1];
      end
    end
  end

  assign prod_o = prod_q[STAGES-1];
  assign busy_o = |vld_q;

  // R6: an empty slot leaving the multiplier carries no value
  assert_empty_slot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[STAGES-1] |-> (prod_o == '0));

endmodule

// File: rtl/dpa_sum_ring.sv
module dpa_sum_ring #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 42,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic signed [ACC_W-1:0]  total_o
);

  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PROD_W-1:0] p);
    logic signed [ACC_W-1:0] w;
    w = p;
    return w;
  endfunction

  logic signed [ACC_W-1:0] ring_q [DEPTH];
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] loop_back;
  logic signed [ACC_W-1:0] sum_next;
  logic                    ovf_evt;

  assign addend    = widen(prod_i);
  assign loop_back = ring_q[DEPTH-1];
  assign sum_next  = addend + loop_back;
  assign ovf_evt   = (addend[ACC_W-1] == loop_back[ACC_W-1]) &&
                     (sum_next[ACC_W-1] != addend[ACC_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      for (int s = 0; s < DEPTH; s++) ring_q[s] <= '0;
    end else begin
      ring_q[0] <= sum_next;
      for (int s = 1; s < DEPTH; s++) ring_q[s] <= ring_q[s-1];
    end
  end

  always_comb begin
    total_o = '0;
    for (int s = 0; s < DEPTH; s++) total_o = total_o + ring_q[s];
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt);

  // R10: the ring starts empty for the next vector
  assert_ring_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (total_o == '0));

endmodule

// File: rtl/dpa_seq.sv
module dpa_seq
  import dpa_pkg::*;
#(
  parameter int MUL_STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic ready_o,
  output logic take_o,
  output logic reduce_o
);

  localparam int CW = $clog2(MUL_STAGES + 1);
  localparam logic [CW-1:0] LIM = CW'(MUL_STAGES);

  dpa_state_t    state_q;
  logic [CW-1:0] cnt_q;

  assign ready_o  = (state_q == ST_ACCUM);
  assign take_o   = in_valid && ready_o;
  assign reduce_o = (state_q == ST_DRAIN) && (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACCUM;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_ACCUM: if (take_o && in_last) begin
          state_q <= ST_DRAIN;
          cnt_q   <= '0;
        end
        ST_DRAIN: if (cnt_q == LIM) state_q <= ST_ACCUM;
                  else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_ACCUM;
      endcase
    end
  end

  // R4: the drain ends on its own before the counter can wrap
  assert_drain_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (cnt_q <= LIM));

endmodule

// File: rtl/dot_product_accum.sv
module dot_product_accum #(
  parameter int OP_W       = 16,
  parameter int MAX_LEN    = 1024,
  parameter int MUL_STAGES = 4,
  parameter int ADD_STAGES = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  input  logic                                      in_last,
  input  logic signed [OP_W-1:0]                    in_a,
  input  logic signed [OP_W-1:0]                    in_b,
  output logic                                      in_ready,
  output logic                                      out_valid,
  output logic signed [2*OP_W+$clog2(MAX_LEN)-1:0]  out_sum
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + $clog2(MAX_LEN);

  logic                     take_evt;
  logic                     reduce_evt;
  logic                     mul_busy;
  logic signed [PROD_W-1:0] mul_prod;
  logic signed [ACC_W-1:0]  ring_total;

  dpa_seq #(.MUL_STAGES(MUL_STAGES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .ready_o  (in_ready),
    .take_o   (take_evt),
    .reduce_o (reduce_evt)
  );

  dpa_mult_pipe #(.OP_W(OP_W), .STAGES(MUL_STAGES)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take_evt),
    .a_i    (in_a),
    .b_i    (in_b),
    .prod_o (mul_prod),
    .busy_o (mul_busy)
  );

  dpa_sum_ring #(.PROD_W(PROD_W), .ACC_W(ACC_W), .DEPTH(ADD_STAGES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (reduce_evt),
    .prod_i  (mul_prod),
    .total_o (ring_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= reduce_evt;
      if (reduce_evt) out_sum <= ring_total;
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_ready_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);

  assert_pipe_drained_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reduce_evt |-> !mul_busy);

  assert_sum_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sum));

endmodule

// File: tb/sim_dot_product_accum.sv
`timescale 1ns/1ps
module sim_dot_product_accum;

  localparam int OP_W   = 16;
  localparam int MAXL   = 1024;
  localparam int MUL_ST = 4;
  localparam int SUM_W  = 2 * OP_W + $clog2(MAXL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic signed [OP_W-1:0] in_a = '0;
  logic signed [OP_W-1:0] in_b = '0;
  logic in_ready;
  logic out_valid;
  logic signed [SUM_W-1:0] out_sum;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dot_product_accum #(.OP_W(OP_W), .MAX_LEN(MAXL), .MUL_STAGES(MUL_ST), .ADD_STAGES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // behavioural reference, advanced on each rising edge
  bit     m_busy = 0;
  int     m_cd = 0;
  bit     m_done = 0;
  longint m_acc = 0;
  longint m_sum = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cd = 0; m_done = 0; m_acc = 0; m_sum = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cd--;
        if (m_cd == 0) begin
          m_done = 1; m_sum = m_acc; m_acc = 0; m_busy = 0;
        end
      end else if (in_valid) begin
        m_acc += longint'(in_a) * longint'(in_b);
        if (in_last) begin m_busy = 1; m_cd = MUL_ST + 1; end
      end
    end
  end

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1/R4 in_ready", longint'(in_ready), longint'(!m_busy));
      check("R3 out_valid", longint'(out_valid), longint'(m_done));
      check("R2/R9 out_sum", longint'(out_sum), m_sum);
    end
  end

  task automatic idle();
    in_valid = 0; in_last = 0; in_a = '0; in_b = '0;
  endtask

  // mode 0: small ramp, 1: idle gaps, 2: most negative operands, 3: random
  task automatic run_vec(input int len, input int mode, input string tag);
    longint exp = 0;
    logic signed [OP_W-1:0] a;
    logic signed [OP_W-1:0] b;
    int guard;
    for (int i = 0; i < len; i++) begin
      case (mode)
        0: begin a = OP_W'(i + 1); b = OP_W'(3 - 2 * i); end
        1: begin a = OP_W'(7 * i - 20); b = OP_W'(i + 5); end
        2: begin a = -16'sd32768; b = -16'sd32768; end
        default: begin a = OP_W'($urandom); b = OP_W'($urandom); end
      endcase
      while (!in_ready) begin idle(); @(negedge clk); end
      in_valid = 1; in_last = (i == len - 1); in_a = a; in_b = b;
      exp += longint'(a) * longint'(b);
      @(negedge clk);
      if (mode == 1 && (i % 3) == 1 && i != len - 1) begin
        idle(); repeat (2) @(negedge clk);
      end
    end
    guard = 0;
    while (!out_valid && guard < 50) begin
      // R4: junk offered while the block drains must be ignored
      in_valid = 1; in_last = 1; in_a = 16'sh1234; in_b = -16'sd77;
      @(negedge clk);
      guard++;
    end
    idle();
    check(tag, longint'(out_sum), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 ready after reset", longint'(in_ready), 1);
    check("R8 out_valid after reset", longint'(out_valid), 0);
    check("R8 out_sum after reset", longint'(out_sum), 0);
    rst_n = 1;
    @(negedge clk);
    run_vec(1, 0, "R5 length 1");
    run_vec(2, 0, "R5 length 2");
    run_vec(3, 3, "R5 length 3");
    run_vec(4, 0, "R2 length 4");
    run_vec(5, 3, "R2 length 5");
    run_vec(9, 0, "R1 unbroken length 9");
    run_vec(11, 1, "R6 gapped length 11");
    run_vec(17, 3, "R10 back to back 17");
    run_vec(6, 3, "R10 back to back 6");
    run_vec(MAXL, 2, "R7 full length extreme");
    run_vec(40, 3, "R2 random 40");
    repeat (10) @(negedge clk);
    check("R9 held after idle", longint'(out_valid), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule